// File: doc/BRIEF.md
# Checker-side snoop-filled data cache

This block is a small private data cache for an in-order checker pipeline that re-executes every retired instruction of a speculative core. Most of its lines arrive before the checker asks for them. Whenever the core's first-level data cache returns a line on its read port, the block copies it in through a snoop fill port. By the time the checker re-executes a load or store, the line is usually present. A line only has to survive from the core's first touch until the checker's re-execution, so 4 KB is enough.

The checker has one load/store port. On a hit, read data is returned in the same cycle. A store that hits writes its word into the line and is presented on the store-queue output in the same cycle. The cache is write-through to that queue, so an evicted line is simply dropped. On a miss, the block raises a stall that freezes the whole checker pipeline and sends a single line request to the second-level cache. It installs the returned line and then completes the access. Snoop fills and checker accesses share the array. When both address the same set in one cycle, the checker access wins and the fill waits in a one-entry holding register.

Top module: `cdc_dcache`

## Requirements
- R1: After reset every line is invalid. With no checker request, `chk_stall_o`, `l2_req_o` and `sq_valid_o` are low and `fill_ready_o` is high. The first checker access after reset misses.
- R2: Address fields are: byte offset `addr[4:0]`, set index `addr[8:5]` (16 sets), tag `addr[31:9]`, and word select `addr[4:2]`. Word k of a line is bits `[32k+31:32k]` of the line vector. After a snoop fill of a line, a checker read of any word in that line hits (`chk_stall_o` low in the same cycle) and returns that word of the fill data.
- R3: A snoop fill whose line is already present overwrites that line in place. Later reads return the new data, and other lines of the set stay resident.
- R4: A fill that misses in a set with an invalid way takes the lowest-numbered invalid way. With all 8 ways valid, it evicts the way chosen by a 7-bit tree pseudo-LRU for that set. Each node bit points toward the less recently used half.
- R5: A checker miss raises `chk_stall_o` in the same cycle. `l2_req_o` pulses for exactly one cycle with a line-aligned `l2_addr_o`. The stall stays high until the cycle after `l2_valid_i` delivers the line, and the held access then completes with the second-level data.
- R6: A checker store that hits writes its word into the cache. In the same cycle, `sq_valid_o` is high with `sq_addr_o`/`sq_data_o` equal to the store's address and data.
- R7: A checker store that misses allocates the line from the second-level cache and then writes its word. `sq_valid_o` is never high while `chk_stall_o` is high.
- R8: A snoop fill that targets the same set as an active checker request in that cycle is deferred into a holding register, and `fill_ready_o` drops. The held fill is applied in the first cycle without a same-set checker request, and `fill_ready_o` then returns high. A fill to a different set is applied in the same cycle as the checker access.
- R9: Checker hits and second-level installs count as uses for replacement, so a line the checker has just read is not the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_req_i | input | 1 | Checker access request; held until `chk_stall_o` is low |
| chk_we_i | input | 1 | Checker access is a store |
| chk_addr_i | input | 32 | Checker byte address (word aligned) |
| chk_wdata_i | input | 32 | Checker store data |
| chk_rdata_o | output | 32 | Checker load data, valid when not stalled |
| chk_stall_o | output | 1 | Checker pipeline stall on miss |
| fill_valid_i | input | 1 | Snoop fill from the core L1 read port |
| fill_addr_i | input | 32 | Snoop fill address |
| fill_line_i | input | 256 | Snoop fill line data |
| fill_ready_o | output | 1 | Holding register empty; fills are ignored while low |
| l2_req_o | output | 1 | Line request to second-level cache |
| l2_addr_o | output | 32 | Line-aligned request address |
| l2_valid_i | input | 1 | Second-level line return |
| l2_line_i | input | 256 | Second-level line data |
| sq_valid_o | output | 1 | Committed checker store to store queue |
| sq_addr_o | output | 32 | Store address |
| sq_data_o | output | 32 | Store data |

## Verification
A checker access and a snoop fill can land in the same cycle. The bench provokes this twice. In one case it holds a checker read on a set for two cycles while a fill to that same set arrives. In the other, the read and the fill address different sets. The bench judges both cases at the ports. It checks that the read hit with correct data in the contended cycle and watches `fill_ready_o` fall and later rise. It then checks that a later read of the filled line hits with the fill data. A second collision comes from the miss path: a line return installs a line and completes the stalled access. The bench judges this by the exact stall length and the returned word.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_WORD_W     = 32;
  localparam int unsigned DEF_LINE_BYTES = 32;
  localparam int unsigned DEF_WAYS       = 8;
  localparam int unsigned DEF_SETS       = 16;

  typedef enum logic {MS_IDLE, MS_WAIT} miss_state_e;
endpackage

// File: rtl/cdc_way_match.sv
module cdc_way_match #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 23,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0]      tag_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]       vld_i,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      hit_way_o,
  output logic                  free_o,
  output logic [WAY_W-1:0]      free_way_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    hit_o     = |hit_vec;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end

  // lowest-numbered invalid way
  always_comb begin
    free_o     = ~&vld_i;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_i[w]) free_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/cdc_plru.sv
module cdc_plru #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 8,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned NB    = WAYS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ta_en_i,
  input  logic [IDX_W-1:0] ta_set_i,
  input  logic [WAY_W-1:0] ta_way_i,
  input  logic             tb_en_i,
  input  logic [IDX_W-1:0] tb_set_i,
  input  logic [WAY_W-1:0] tb_way_i,
  input  logic [IDX_W-1:0] qa_set_i,
  output logic [WAY_W-1:0] qa_way_o,
  input  logic [IDX_W-1:0] qb_set_i,
  output logic [WAY_W-1:0] qb_way_o
);
  logic [NB-1:0] bits_q [SETS];

  // node bit = 1 : victim lies in the upper half
  function automatic logic [NB-1:0] touch(input logic [NB-1:0] b, input logic [WAY_W-1:0] w);
    int n;
    logic d;
    n = 0;
    for (int l = 0; l < WAY_W; l++) begin
      d    = w[WAY_W-1-l];
      b[n] = ~d;
      n    = 2 * n + 1 + 32'(d);
    end
    return b;
  endfunction

  function automatic logic [WAY_W-1:0] victim(input logic [NB-1:0] b);
    int n;
    logic d;
    logic [WAY_W-1:0] w;
    n = 0;
    w = '0;
    for (int l = 0; l < WAY_W; l++) begin
      d            = b[n];
      w[WAY_W-1-l] = d;
      n            = 2 * n + 1 + 32'(d);
    end
    return w;
  endfunction

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bits_q[s] <= '0;
      end else if ((ta_en_i && ta_set_i == IDX_W'(s)) || (tb_en_i && tb_set_i == IDX_W'(s))) begin
        if (ta_en_i && ta_set_i == IDX_W'(s) && tb_en_i && tb_set_i == IDX_W'(s))
          bits_q[s] <= touch(touch(bits_q[s], ta_way_i), tb_way_i);
        else if (ta_en_i && ta_set_i == IDX_W'(s))
          bits_q[s] <= touch(bits_q[s], ta_way_i);
        else
          bits_q[s] <= touch(bits_q[s], tb_way_i);
      end
    end
  end

  assign qa_way_o = victim(bits_q[qa_set_i]);
  assign qb_way_o = victim(bits_q[qb_set_i]);
endmodule

// File: rtl/cdc_miss_ctrl.sv
module cdc_miss_ctrl
  import cdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hit_i,
  input  logic l2_valid_i,
  output logic stall_o,
  output logic l2_req_o,
  output logic install_o
);
  miss_state_e state_q, state_d;

  assign stall_o   = req_i && !hit_i;
  assign l2_req_o  = stall_o && (state_q == MS_IDLE);
  assign install_o = stall_o && (state_q == MS_WAIT) && l2_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MS_IDLE: if (l2_req_o)   state_d = MS_WAIT;
      MS_WAIT: if (l2_valid_i) state_d = MS_IDLE;
      default: state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/cdc_dcache.sv
module cdc_dcache
  import cdc_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned WAYS       = DEF_WAYS,
  parameter int unsigned SETS       = DEF_SETS,
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_req_i,
  input  logic              chk_we_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [WORD_W-1:0] chk_wdata_i,
  output logic [WORD_W-1:0] chk_rdata_o,
  output logic              chk_stall_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              fill_ready_o,
  output logic              l2_req_o,
  output logic [ADDR_W-1:0] l2_addr_o,
  input  logic              l2_valid_i,
  input  logic [LINE_W-1:0] l2_line_i,
  output logic              sq_valid_o,
  output logic [ADDR_W-1:0] sq_addr_o,
  output logic [WORD_W-1:0] sq_data_o
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned WPL    = LINE_W / WORD_W;
  localparam int unsigned WSEL_W = $clog2(WPL);
  localparam int unsigned BOFF   = $clog2(WORD_W / 8);
  localparam int unsigned LA_W   = ADDR_W - OFF_W;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];

  // checker side
  logic [IDX_W-1:0]      c_idx;
  logic [TAG_W-1:0]      c_tag;
  logic [WSEL_W-1:0]     c_wsel;
  logic [WAYS*TAG_W-1:0] c_tags;
  logic                  c_hit, c_free;
  logic [WAY_W-1:0]      c_way, c_free_way, c_plru_way, c_inst_way;
  logic                  install, st_do;
  logic [LINE_W-1:0]     c_line;

  assign c_idx  = chk_addr_i[OFF_W +: IDX_W];
  assign c_tag  = chk_addr_i[ADDR_W-1 -: TAG_W];
  assign c_wsel = chk_addr_i[BOFF +: WSEL_W];

  always_comb
    for (int w = 0; w < WAYS; w++) c_tags[w*TAG_W +: TAG_W] = tag_q[c_idx][w];

  cdc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmatch (
    .tag_i(c_tag), .tags_i(c_tags), .vld_i(vld_q[c_idx]),
    .hit_o(c_hit), .hit_way_o(c_way), .free_o(c_free), .free_way_o(c_free_way)
  );

  cdc_miss_ctrl u_miss (
    .clk_i, .rst_ni, .req_i(chk_req_i), .hit_i(c_hit), .l2_valid_i,
    .stall_o(chk_stall_o), .l2_req_o, .install_o(install)
  );

  assign c_inst_way  = c_free ? c_free_way : c_plru_way;
  assign l2_addr_o   = {chk_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign c_line      = data_q[c_idx][c_way];
  assign chk_rdata_o = c_line[c_wsel*WORD_W +: WORD_W];
  assign st_do       = chk_req_i && chk_we_i && c_hit;
  assign sq_valid_o  = st_do;
  assign sq_addr_o   = chk_addr_i;
  assign sq_data_o   = chk_wdata_i;

  // snoop fill side with one-entry holding register
  logic              fbuf_v_q;
  logic [LA_W-1:0]   fbuf_la_q;
  logic [LINE_W-1:0] fbuf_line_q;
  logic              f_valid, f_conflict, f_apply;
  logic [LA_W-1:0]   f_la;
  logic [LINE_W-1:0] f_line;
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic [WAYS*TAG_W-1:0] f_tags;
  logic              f_hit, f_free;
  logic [WAY_W-1:0]  f_hit_way, f_free_way, f_plru_way, f_vict;

  assign fill_ready_o = !fbuf_v_q;
  assign f_valid      = fbuf_v_q || fill_valid_i;
  assign f_la         = fbuf_v_q ? fbuf_la_q : fill_addr_i[ADDR_W-1:OFF_W];
  assign f_line       = fbuf_v_q ? fbuf_line_q : fill_line_i;
  assign f_idx        = f_la[IDX_W-1:0];
  assign f_tag        = f_la[LA_W-1 -: TAG_W];
  assign f_conflict   = chk_req_i && (f_idx == c_idx);
  assign f_apply      = f_valid && !f_conflict;

  always_comb
    for (int w = 0; w < WAYS; w++) f_tags[w*TAG_W +: TAG_W] = tag_q[f_idx][w];

  cdc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fmatch (
    .tag_i(f_tag), .tags_i(f_tags), .vld_i(vld_q[f_idx]),
    .hit_o(f_hit), .hit_way_o(f_hit_way), .free_o(f_free), .free_way_o(f_free_way)
  );

  assign f_vict = f_hit ? f_hit_way : (f_free ? f_free_way : f_plru_way);

  cdc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk_i, .rst_ni,
    .ta_en_i((chk_req_i && c_hit) || install), .ta_set_i(c_idx),
    .ta_way_i(install ? c_inst_way : c_way),
    .tb_en_i(f_apply), .tb_set_i(f_idx), .tb_way_i(f_vict),
    .qa_set_i(c_idx), .qa_way_o(c_plru_way),
    .qb_set_i(f_idx), .qb_way_o(f_plru_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fbuf_v_q <= 1'b0;
    end else if (fbuf_v_q) begin
      fbuf_v_q <= f_conflict;
    end else begin
      fbuf_v_q <= fill_valid_i && f_conflict;
    end
  end

  always_ff @(posedge clk_i)
    if (!fbuf_v_q && fill_valid_i) begin
      fbuf_la_q   <= fill_addr_i[ADDR_W-1:OFF_W];
      fbuf_line_q <= fill_line_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (install) vld_q[c_idx][c_inst_way] <= 1'b1;
      if (f_apply) vld_q[f_idx][f_vict]     <= 1'b1;
    end
  end

  // fill and checker never share a set in one cycle
  always_ff @(posedge clk_i) begin
    if (st_do) data_q[c_idx][c_way][c_wsel*WORD_W +: WORD_W] <= chk_wdata_i;
    if (install) begin
      data_q[c_idx][c_inst_way] <= l2_line_i;
      tag_q[c_idx][c_inst_way]  <= c_tag;
    end
    if (f_apply) begin
      data_q[f_idx][f_vict] <= f_line;
      tag_q[f_idx][f_vict]  <= f_tag;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{chk_addr_i[BOFF-1:0], fill_addr_i[OFF_W-1:0]};
endmodule

// File: rtl/cdc_dcache_sva.sv
module cdc_dcache_sva #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chk_req_i,
  input logic              chk_we_i,
  input logic [ADDR_W-1:0] chk_addr_i,
  input logic              chk_stall_o,
  input logic              fill_valid_i,
  input logic              fill_ready_o,
  input logic              l2_req_o,
  input logic              l2_valid_i,
  input logic              sq_valid_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_req_i |-> (!chk_stall_o && !l2_req_o && !sq_valid_o));

  a_r5_req_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o |-> chk_stall_o);

  a_r5_single_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o |=> !l2_req_o);

  a_r5_release_after_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_stall_o && l2_valid_i && !l2_req_o) ##1 (chk_req_i && $stable(chk_addr_i))
      |-> !chk_stall_o);

  a_r7_store_not_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_valid_o |-> (chk_req_i && chk_we_i && !chk_stall_o));

  a_r8_defer_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fill_ready_o) |-> $past(fill_valid_i && chk_req_i));

  a_r8_retry_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_ready_o && !chk_req_i) |=> fill_ready_o);
endmodule

bind cdc_dcache cdc_dcache_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .chk_req_i(chk_req_i), .chk_we_i(chk_we_i),
  .chk_addr_i(chk_addr_i), .chk_stall_o(chk_stall_o), .fill_valid_i(fill_valid_i),
  .fill_ready_o(fill_ready_o), .l2_req_o(l2_req_o), .l2_valid_i(l2_valid_i),
  .sq_valid_o(sq_valid_o)
);

// File: tb/tb_cdc_dcache.sv
module tb_cdc_dcache;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chk_req = 1'b0, chk_we = 1'b0;
  logic [31:0]  chk_addr = '0, chk_wdata = '0;
  logic [31:0]  chk_rdata;
  logic         chk_stall;
  logic         fill_valid = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [255:0] fill_line = '0;
  logic         fill_ready;
  logic         l2_req;
  logic [31:0]  l2_addr;
  logic         l2_valid = 1'b0;
  logic [255:0] l2_line = '0;
  logic         sq_valid;
  logic [31:0]  sq_addr, sq_data;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  cdc_dcache dut (
    .clk_i(clk), .rst_ni(rst_n),
    .chk_req_i(chk_req), .chk_we_i(chk_we), .chk_addr_i(chk_addr), .chk_wdata_i(chk_wdata),
    .chk_rdata_o(chk_rdata), .chk_stall_o(chk_stall),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .fill_line_i(fill_line),
    .fill_ready_o(fill_ready),
    .l2_req_o(l2_req), .l2_addr_o(l2_addr), .l2_valid_i(l2_valid), .l2_line_i(l2_line),
    .sq_valid_o(sq_valid), .sq_addr_o(sq_addr), .sq_data_o(sq_data)
  );

  function automatic logic [31:0] mk(input int tag, input int set);
    return {23'(tag), 4'(set), 5'b0};
  endfunction

  function automatic logic [31:0] wpat(input logic [31:0] la, input int k, input int gen);
    return la ^ (32'(k) * 32'h0101_0101) ^ (32'(gen) * 32'h5A00_0013);
  endfunction

  function automatic logic [255:0] lpat(input logic [31:0] la, input int gen);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = wpat(la, k, gen);
    return l;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input int gen);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_line = lpat({a[31:5], 5'b0}, gen);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // checker access; a second-level model answers LAT cycles after a request
  logic        last_sqv;
  logic [31:0] last_sqa, last_sqd, last_l2a;
  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int nreq, output int ncyc);
    int wcnt;
    @(negedge clk);
    chk_req = 1'b1; chk_we = we; chk_addr = a; chk_wdata = wd;
    nreq = 0; ncyc = 0; wcnt = -1;
    forever begin
      #1;
      if (!chk_stall) begin
        rd = chk_rdata; last_sqv = sq_valid; last_sqa = sq_addr; last_sqd = sq_data;
        break;
      end
      if (l2_req) begin nreq++; last_l2a = l2_addr; wcnt = 0; end
      if (ncyc > 50) break;
      @(negedge clk);
      l2_valid = 1'b0;
      ncyc++;
      if (wcnt >= 0) wcnt++;
      if (wcnt == LAT) begin
        l2_valid = 1'b1; l2_line = lpat(last_l2a, 7); wcnt = -1;
      end
    end
    @(negedge clk);
    chk_req = 1'b0; chk_we = 1'b0; l2_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int nreq, ncyc;
    #(CLK_P * 3 + 2);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 fill_ready", 32'(fill_ready), 1);
    check("R1 stall", 32'(chk_stall), 0);
    check("R1 l2_req", 32'(l2_req), 0);
    check("R1 sq_valid", 32'(sq_valid), 0);

    // R1/R5 first access misses and is served from second level
    access(1'b0, mk(1, 0) + 8, '0, rd, nreq, ncyc);
    check("R1 first access misses", 32'(nreq), 1);
    check("R5 line aligned request", last_l2a, mk(1, 0));
    check("R5 stall length", 32'(ncyc), LAT + 1);
    check("R5 returned word", rd, wpat(mk(1, 0), 2, 7));

    // R2 sweep: one line in every set, every word read back
    for (int s = 0; s < 16; s++) do_fill(mk(2, s) + 4, 1);
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 8; k++) begin
        access(1'b0, mk(2, s) + 32'(4 * k), '0, rd, nreq, ncyc);
        check("R2 fill hit", 32'(nreq), 0);
        check("R2 fill data", rd, wpat(mk(2, s), k, 1));
      end

    // R3 in-place update
    do_fill(mk(9, 4), 1);
    do_fill(mk(2, 4), 2);
    access(1'b0, mk(2, 4) + 12, '0, rd, nreq, ncyc);
    check("R3 updated data", rd, wpat(mk(2, 4), 3, 2));
    access(1'b0, mk(9, 4) + 4, '0, rd, nreq, ncyc);
    check("R3 neighbour resident", 32'(nreq), 0);

    // R6 store hit
    access(1'b1, mk(2, 6) + 8, 32'hDEAD_BEEF, rd, nreq, ncyc);
    check("R6 store hit", 32'(nreq), 0);
    check("R6 sq_valid", 32'(last_sqv), 1);
    check("R6 sq_addr", last_sqa, mk(2, 6) + 8);
    check("R6 sq_data", last_sqd, 32'hDEAD_BEEF);
    access(1'b0, mk(2, 6) + 8, '0, rd, nreq, ncyc);
    check("R6 readback", rd, 32'hDEAD_BEEF);
    access(1'b0, mk(2, 6) + 12, '0, rd, nreq, ncyc);
    check("R6 other word", rd, wpat(mk(2, 6), 3, 1));

    // R7 store miss allocates
    access(1'b1, mk(3, 7) + 12, 32'h1234_5678, rd, nreq, ncyc);
    check("R7 store miss request", 32'(nreq), 1);
    check("R7 sq after fetch", 32'(last_sqv), 1);
    check("R7 sq_data", last_sqd, 32'h1234_5678);
    access(1'b0, mk(3, 7) + 12, '0, rd, nreq, ncyc);
    check("R7 stored word", rd, 32'h1234_5678);
    access(1'b0, mk(3, 7), '0, rd, nreq, ncyc);
    check("R7 rest of line", rd, wpat(mk(3, 7), 0, 7));

    // R4/R9 replacement in set 11: way0 holds mk(2,11); fill ways 1..7
    for (int i = 0; i < 7; i++) do_fill(mk(20 + i, 11), 1);
    access(1'b0, mk(2, 11), '0, rd, nreq, ncyc);
    check("R9 touch hit", 32'(nreq), 0);
    do_fill(mk(30, 11), 1); // tree points at way4 = mk(23,11)
    access(1'b0, mk(2, 11), '0, rd, nreq, ncyc);
    check("R9 recently read line kept", 32'(nreq), 0);
    access(1'b0, mk(20, 11) + 4, '0, rd, nreq, ncyc);
    check("R4 way1 kept", 32'(nreq), 0);
    access(1'b0, mk(30, 11) + 20, '0, rd, nreq, ncyc);
    check("R4 new line data", rd, wpat(mk(30, 11), 5, 1));
    check("R4 new line hit", 32'(nreq), 0);
    access(1'b0, mk(23, 11), '0, rd, nreq, ncyc);
    check("R4 victim evicted", 32'(nreq), 1);

    // R8 same-set collision, checker held two cycles
    @(negedge clk);
    chk_req = 1'b1; chk_we = 1'b0; chk_addr = mk(2, 12);
    fill_valid = 1'b1; fill_addr = mk(40, 12); fill_line = lpat(mk(40, 12), 3);
    #1;
    check("R8 checker wins stall", 32'(chk_stall), 0);
    check("R8 checker wins data", chk_rdata, wpat(mk(2, 12), 0, 1));
    @(negedge clk);
    fill_valid = 1'b0; #1;
    check("R8 fill deferred", 32'(fill_ready), 0);
    @(negedge clk);
    chk_req = 1'b0; #1;
    check("R8 still held", 32'(fill_ready), 0);
    @(negedge clk); #1;
    check("R8 retried", 32'(fill_ready), 1);
    access(1'b0, mk(40, 12) + 20, '0, rd, nreq, ncyc);
    check("R8 deferred fill hit", 32'(nreq), 0);
    check("R8 deferred fill data", rd, wpat(mk(40, 12), 5, 3));

    // R8 different sets proceed together
    @(negedge clk);
    chk_req = 1'b1; chk_addr = mk(2, 13);
    fill_valid = 1'b1; fill_addr = mk(41, 14); fill_line = lpat(mk(41, 14), 3);
    @(negedge clk);
    chk_req = 1'b0; fill_valid = 1'b0; #1;
    check("R8 no deferral", 32'(fill_ready), 1);
    access(1'b0, mk(41, 14) + 28, '0, rd, nreq, ncyc);
    check("R8 parallel fill data", rd, wpat(mk(41, 14), 7, 3));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule